// File: doc/BRIEF.md
# Interrupt Controller Redirection Register File

This block holds the software-visible register space of an I/O interrupt controller. Software never addresses an internal register directly. It first writes an index into a select register, then reads or writes a 32-bit data window that maps onto the register the index names. Behind the window sit three registers:

- a read-only version register;
- an ID register;
- an arbitration ID register that mirrors the ID.

Next to these are one 64-bit redirection entry per interrupt pin, each reached as an even (lower) and an odd (upper) 32-bit half.

The stored entry fields leave the block on flat per-pin output buses for the routing logic. Each entry write is checked against the pin's input line. A level-triggered, unmasked entry with a pending line and no outstanding remote IRR gets its remote IRR set, and a one-cycle delivery request naming the pin is raised. Destination resolution and end-of-interrupt handling belong to neighbouring blocks.

Top module: `ioapic_regfile`

## Requirements
- R1: After reset the select register reads 0, the ID is 0, and every redirection entry reads lower half 0x00010000 (masked, all other fields 0) and upper half 0.
- R2: Only the low 8 bits of the bus address are decoded. The select register is at offset 0x00 (bits 7:0) and the data window is at 0x10. Reads of any other offset return 0, and writes to them change nothing.
- R3: Select 0x01 reads the version register as (pin count − 1) in bits 23:16 and the version code in bits 7:0, which is 0x00170011 with default parameters. Writes to it are ignored.
- R4: Select 0x00 is the ID register: bits 27:24 are writable and all other bits read 0. Select 0x02 reads the same value and ignores writes.
- R5: For select ≥ 0x10 the entry index is (select − 0x10) >> 1. An even select reaches the lower half and an odd select the upper half. The lower half has vector in bits 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote IRR in 14, trigger mode in 15 (1 = level) and mask in 16.
- R6: The upper half stores only bits 31:24 (destination). Its other bits, and bits 31:17 of the lower half, read 0.
- R7: Selects 0x03 to 0x0F and entry indices at or beyond the pin count read 0, and writes through them change no entry.
- R8: A lower-half write keeps the stored remote IRR and stores delivery status as 0. Remote IRR never goes from 1 to 0 except by reset.
- R9: After a write to either half of an entry that is level-triggered, unmasked and has remote IRR clear while its input line is high, the next cycle shows remote IRR = 1 and dlv_req high for one cycle with dlv_pin equal to the index.
- R10: No delivery request follows an entry write when the entry is edge-triggered, masked, already has remote IRR set, or its line is low.
- R11: The per-pin output buses show the stored entry fields, and they change only after a window write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset, low 8 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_en is high |
| irq_line | input | NPINS | Per-pin asserted input line |
| out_vector | output | NPINS*8 | Vector of each entry |
| out_dlvmode | output | NPINS*3 | Delivery mode of each entry |
| out_dstmode | output | NPINS | Destination mode of each entry |
| out_polarity | output | NPINS | Polarity of each entry |
| out_level | output | NPINS | Trigger mode of each entry (1 = level) |
| out_mask | output | NPINS | Mask of each entry |
| out_rirr | output | NPINS | Remote IRR of each entry |
| out_dest | output | NPINS*8 | Destination of each entry |
| dlv_req | output | 1 | One-cycle delivery request |
| dlv_pin | output | PIN_W | Pin index of the request |

## Verification
The hardest situation to reach is the re-trigger on a write. It needs a level-triggered, unmasked entry with remote IRR clear and a high input line, all in the same cycle as the entry write. It must also be told apart from the four near-misses, where exactly one of those conditions fails.

The stimulus drives each pin's line directly and builds each case on its own pin. It then checks the request strobe and the remote IRR bit one edge after the write. The upper-half route to a request is reached by programming an unmasked level entry while its line is low, raising the line, and then writing only the destination half.

// File: rtl/ioapic_regfile.sv
module ioapic_regfile #(
  parameter int NPINS = 24,
  parameter int ADDR_W = 12,
  parameter logic [7:0] VERSION = 8'h11,
  parameter logic [7:0] SEL_OFF = 8'h00,
  parameter logic [7:0] WIN_OFF = 8'h10,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    irq_line,
  output logic [NPINS*8-1:0]  out_vector,
  output logic [NPINS*3-1:0]  out_dlvmode,
  output logic [NPINS-1:0]    out_dstmode,
  output logic [NPINS-1:0]    out_polarity,
  output logic [NPINS-1:0]    out_level,
  output logic [NPINS-1:0]    out_mask,
  output logic [NPINS-1:0]    out_rirr,
  output logic [NPINS*8-1:0]  out_dest,
  output logic                dlv_req,
  output logic [PIN_W-1:0]    dlv_pin
);
  localparam logic [7:0] S_ID   = 8'h00;
  localparam logic [7:0] S_VER  = 8'h01;
  localparam logic [7:0] S_ARB  = 8'h02;
  localparam logic [7:0] S_TBL  = 8'h10;
  localparam logic [7:0] LAST_IDX = 8'(NPINS - 1);
  localparam int B_RIRR = 14;
  localparam int B_LVL  = 15;
  localparam int B_MSK  = 16;

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic [16:0] lo_q   [NPINS];
  logic [7:0]  dest_q [NPINS];

  logic [7:0]       off;
  logic             is_sel, is_win, wr_sel, wr_win;
  logic [7:0]       rel;
  logic [6:0]       idx;
  logic [PIN_W-1:0] pidx;
  logic             hi, in_tbl, ent_wr, fire;
  logic [16:0]      cur_lo, new_lo;
  logic [31:0]      win_rd;

  assign off    = bus_addr[7:0];
  assign is_sel = (off == SEL_OFF);
  assign is_win = (off == WIN_OFF);
  assign wr_sel = bus_en && bus_we && is_sel;
  assign wr_win = bus_en && bus_we && is_win;

  assign rel    = sel_q - S_TBL;
  assign idx    = rel[7:1];
  assign pidx   = idx[PIN_W-1:0];
  assign hi     = sel_q[0];
  assign in_tbl = (sel_q >= S_TBL) && ({1'b0, idx} <= LAST_IDX);
  assign ent_wr = wr_win && in_tbl;

  assign cur_lo = in_tbl ? lo_q[pidx] : 17'h0;
  assign new_lo = hi ? cur_lo
                     : {bus_wdata[16:15], cur_lo[B_RIRR], bus_wdata[13], 1'b0, bus_wdata[11:0]};

  assign fire = ent_wr && new_lo[B_LVL] && !new_lo[B_MSK] && !cur_lo[B_RIRR] && irq_line[pidx];

  always_comb begin
    win_rd = 32'h0;
    case (sel_q)
      S_ID, S_ARB: win_rd = {4'h0, id_q, 24'h0};
      S_VER:       win_rd = {8'h0, LAST_IDX, 8'h0, VERSION};
      default:
        if (in_tbl) win_rd = hi ? {dest_q[pidx], 24'h0} : {15'h0, lo_q[pidx]};
    endcase
  end

  assign bus_rdata = !bus_en ? 32'h0 :
                     is_sel  ? {24'h0, sel_q} :
                     is_win  ? win_rd : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 8'h0;
      id_q    <= 4'h0;
      dlv_req <= 1'b0;
      dlv_pin <= '0;
      for (int i = 0; i < NPINS; i++) begin
        lo_q[i]   <= 17'h10000;
        dest_q[i] <= 8'h0;
      end
    end else begin
      dlv_req <= fire;
      if (fire) dlv_pin <= pidx;
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && sel_q == S_ID) id_q <= bus_wdata[27:24];
      if (ent_wr) begin
        lo_q[pidx] <= new_lo | {2'b0, fire, 14'h0};
        if (hi) dest_q[pidx] <= bus_wdata[31:24];
      end
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_out
    assign out_vector[g*8 +: 8]  = lo_q[g][7:0];
    assign out_dlvmode[g*3 +: 3] = lo_q[g][10:8];
    assign out_dstmode[g]        = lo_q[g][11];
    assign out_polarity[g]       = lo_q[g][13];
    assign out_rirr[g]           = lo_q[g][B_RIRR];
    assign out_level[g]          = lo_q[g][B_LVL];
    assign out_mask[g]           = lo_q[g][B_MSK];
    assign out_dest[g*8 +: 8]    = dest_q[g];
  end
endmodule

module ioapic_regfile_chk #(
  parameter int NPINS = 24,
  parameter int ADDR_W = 12,
  parameter int PIN_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NPINS-1:0]   out_level,
  input logic [NPINS-1:0]   out_mask,
  input logic [NPINS-1:0]   out_rirr,
  input logic               dlv_req,
  input logic [PIN_W-1:0]   dlv_pin
);
  logic win_wr;
  assign win_wr = bus_en && bus_we && (bus_addr[7:0] == 8'h10);

  AST_REQ_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req |-> out_rirr[dlv_pin]);                                    // R9
  AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req |-> $past(win_wr));                                        // R9
  AST_RIRR_RISE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_rirr & ~$past(out_rirr)) != '0) |-> dlv_req);                // R9
  AST_RIRR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_rirr) & ~out_rirr) == '0);                              // R8
  AST_REQ_LEVEL_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_req |-> (out_level[dlv_pin] && !out_mask[dlv_pin]));           // R10
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_wr) |-> ($stable(out_mask) && $stable(out_level)));     // R11
endmodule

bind ioapic_regfile ioapic_regfile_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .PIN_W(PIN_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .out_level(out_level), .out_mask(out_mask), .out_rirr(out_rirr),
  .dlv_req(dlv_req), .dlv_pin(dlv_pin));

// File: tb/test_ioapic_regfile.sv
module test_ioapic_regfile;
  localparam int N = 24;
  localparam int AW = 12;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] irq_line = '0;
  logic [N*8-1:0] out_vector, out_dest;
  logic [N*3-1:0] out_dlvmode;
  logic [N-1:0] out_dstmode, out_polarity, out_level, out_mask, out_rirr;
  logic dlv_req;
  logic [PW-1:0] dlv_pin;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ioapic_regfile #(.NPINS(N), .ADDR_W(AW)) i_ioapic_regfile (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line),
    .out_vector(out_vector), .out_dlvmode(out_dlvmode), .out_dstmode(out_dstmode),
    .out_polarity(out_polarity), .out_level(out_level), .out_mask(out_mask),
    .out_rirr(out_rirr), .out_dest(out_dest), .dlv_req(dlv_req), .dlv_pin(dlv_pin));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic win_rd(logic [7:0] s, output logic [31:0] d);
    wr(12'h000, {24'h0, s});
    rd(12'h010, d);
  endtask

  task automatic win_wr(logic [7:0] s, logic [31:0] d);
    wr(12'h000, {24'h0, s});
    wr(12'h010, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h000, d);                check("R1 select", d, 32'h0);
    check("R1 mask outputs", 32'(out_mask), 32'(24'hFFFFFF));
    check("R1 rirr outputs", 32'(out_rirr), 32'h0);
    win_rd(8'h10, d);              check("R1 entry0 low", d, 32'h00010000);
    win_rd(8'h3F, d);              check("R1 entry23 high", d, 32'h0);
    win_rd(8'h00, d);              check("R1 id", d, 32'h0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(12'h000, 32'h0000_0055);
    rd(12'h000, d);                check("R2 select readback", d, 32'h55);
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, d);                check("R2 other offset reads 0", d, 32'h0);
    rd(12'h000, d);                check("R2 other offset write ignored", d, 32'h55);
    wr(12'h700, 32'h0000_0001);
    rd(12'h310, d);                check("R2 high address bits ignored", d, 32'h00170011);
  endtask

  task automatic t_version();
    logic [31:0] d;
    win_rd(8'h01, d);              check("R3 version", d, 32'h00170011);
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, d);                check("R3 version write ignored", d, 32'h00170011);
  endtask

  task automatic t_id();
    logic [31:0] d;
    win_wr(8'h00, 32'hFFFF_FFFF);
    rd(12'h010, d);                check("R4 id field", d, 32'h0F000000);
    win_rd(8'h02, d);              check("R4 arb mirror", d, 32'h0F000000);
    wr(12'h010, 32'h0);
    win_rd(8'h00, d);              check("R4 arb write ignored", d, 32'h0F000000);
  endtask

  task automatic t_entry();
    logic [31:0] d;
    win_wr(8'h1A, 32'hFFFE_2B5A);
    rd(12'h010, d);                check("R5/R6 entry5 low", d, 32'h00002B5A);
    check("R11 vector out", 32'(out_vector[5*8 +: 8]), 32'h5A);
    check("R11 dlvmode out", 32'(out_dlvmode[5*3 +: 3]), 32'h3);
    check("R11 polarity/dstmode", {30'h0, out_polarity[5], out_dstmode[5]}, 32'h3);
    check("R11 mask cleared", 32'(out_mask[5]), 32'h0);
    win_wr(8'h1B, 32'hC3FF_FFFF);
    rd(12'h010, d);                check("R6 entry5 high", d, 32'hC3000000);
    check("R11 dest out", 32'(out_dest[5*8 +: 8]), 32'hC3);
    win_rd(8'h1C, d);              check("R5 entry6 untouched", d, 32'h00010000);
  endtask

  task automatic t_range();
    logic [31:0] d;
    win_wr(8'h40, 32'h0000_0077);
    rd(12'h010, d);                check("R7 index 24 reads 0", d, 32'h0);
    check("R7 no entry changed", 32'(out_mask), 32'(24'hFFFFDF));
    win_rd(8'h05, d);              check("R7 gap select reads 0", d, 32'h0);
    win_rd(8'h3E, d);              check("R7 last entry intact", d, 32'h00010000);
  endtask

  task automatic t_fire();
    logic [31:0] d;
    irq_line = '0;
    irq_line[3] = 1'b1;
    wr(12'h000, 32'h16);
    wr(12'h010, 32'h0000_D031);
    check("R9 request", {31'h0, dlv_req}, 32'h1);
    check("R9 pin", 32'(dlv_pin), 32'd3);
    check("R9 rirr set", 32'(out_rirr[3]), 32'h1);
    @(negedge clk);
    check("R9 one cycle", {31'h0, dlv_req}, 32'h0);
    rd(12'h010, d);                check("R8 status 0 rirr kept", d, 32'h0000C031);
    wr(12'h010, 32'h0000_8031);
    check("R10 rirr set no request", {31'h0, dlv_req}, 32'h0);
    check("R8 rirr preserved", 32'(out_rirr[3]), 32'h1);
  endtask

  task automatic t_nofire();
    irq_line[4] = 1'b1;
    win_wr(8'h18, 32'h0000_0031);
    check("R10 edge no request", {31'h0, dlv_req}, 32'h0);
    irq_line[6] = 1'b1;
    win_wr(8'h1C, 32'h0001_8031);
    check("R10 masked no request", {31'h0, dlv_req}, 32'h0);
    win_wr(8'h1E, 32'h0000_8031);
    check("R10 line low no request", {31'h0, dlv_req}, 32'h0);
    irq_line[7] = 1'b1;
    win_wr(8'h1F, 32'h0100_0000);
    check("R9 upper write request", {31'h0, dlv_req}, 32'h1);
    check("R9 upper write pin", 32'(dlv_pin), 32'd7);
    check("R10 rirr only on fired pins", 32'(out_rirr), 32'h0000_0088);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_version();
    t_id();
    t_entry();
    t_range();
    t_fire();
    t_nofire();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule